// File: doc/BRIEF.md
# Two-Wire Serial Register Access Slave

This block lets an external master read and write a bank of byte-wide registers over a two-wire serial link. One wire is a clock that the master drives. The other is a data wire that the master and the slave share. The slave runs on a faster system clock. It passes both wires through two-flop synchronizers and finds the link clock edges in its own clock domain. A frame-sequencing state machine then walks through each 19-bit frame. The register contents are always visible to internal logic on a flat output bus.

A frame has 19 bits and the order is fixed:
- an 8-bit register address, most significant bit first;
- a direction bit, where 1 means read;
- a turnaround bit;
- an 8-bit data field, most significant bit first;
- a trailing bit.

The master changes the data wire while the link clock is low. Each bit is taken on the rising link clock edge. On a read, the master stops driving the wire after the direction bit, and the slave drives the turnaround, data and trailing bits. If the link clock stays high longer than `idle_limit_i` system cycles, the state machine returns to the start of a frame. This happens both between frames and when a frame is abandoned partway.

The states of the sequencer and their transitions, each taken on a rising link clock edge unless noted:
- ST_IDLE → ST_ADDR: the first address bit is taken.
- ST_ADDR → ST_RW: the eighth address bit is taken.
- ST_RW → ST_TURN: the direction bit is taken, and for a read the addressed register is latched.
- ST_TURN → ST_DATA: the turnaround bit passes.
- ST_DATA → ST_TAIL: the eighth data bit is taken, and a write commits to the register.
- ST_TAIL → ST_IDLE: the trailing bit passes and the line is released.
- Any state → ST_IDLE: the idle timeout is reached, whatever the link clock does.

Top module: `sreg_link_slave`

## Requirements
- R1: A frame is 19 rising link-clock edges in this order: 8 address bits (MSB first), a direction bit (1 = read, 0 = write), a turnaround bit, 8 data bits (MSB first), and a trailing bit.
- R2: In a write frame, the byte assembled from the 8 data bits is stored into the addressed register when the eighth data bit is taken.
- R3: In a read frame, the slave presents the addressed register MSB first, one bit per data slot. Each bit is set up after the falling link-clock edge, so the master takes it on the next rising edge.
- R4: `link_dat_oe` is raised only in read frames, from the falling link-clock edge that follows the direction bit. It drops after the rising edge of the trailing bit. It never rises during a write frame.
- R5: When the link clock stays high for `idle_limit_i` or more system cycles, the slave returns to the frame start and drops `link_dat_oe`. The next frame is then decoded from its first bit.
- R6: A write frame cut off before its eighth data bit leaves every register unchanged. A write frame cut off after its eighth data bit but before the trailing bit still commits.
- R7: After reset, `link_dat_oe` is 0 and every register reads 0.
- R8: A high link-clock phase shorter than the idle limit inside a frame does not disturb the frame.
- R9: Register `a` is visible at all times on `reg_flat_o[8a+7:8a]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_clk_i | input | 1 | Serial link clock from the master, idles high |
| link_dat_i | input | 1 | Resolved level of the shared data wire |
| idle_limit_i | input | 16 | Number of system cycles of high link clock that ends a frame |
| link_dat_o | output | 1 | Data value the slave drives during a read |
| link_dat_oe | output | 1 | Slave drive enable for the shared data wire |
| reg_flat_o | output | 2048 | All registers, register a at bits [8a+7:8a] |

## Verification
Two functions can land in the same stretch of time: the idle timeout returning the sequencer to the frame start, and the arrival of the next frame's first bit or the commit of a write. This is provoked in three ways:
- Gaps between frames are randomized just above the idle limit.
- Frames are cut off after five data bits, after eight data bits, and in the middle of a read.
- High phases inside a frame are stretched to just under the limit.

The result is judged at the ports. For each case the bench checks whether the cut-off write reached the register, whether the drive enable has dropped, and whether the next frame decodes with the right alignment against a bench model of the register bank.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RW,
        ST_TURN,
        ST_DATA,
        ST_TAIL
    } frame_st_e;

    localparam int unsigned SREG_ADDR_W = 8;
    localparam int unsigned SREG_DATA_W = 8;
    localparam int unsigned SREG_IDLE_W = 16;
    localparam int unsigned SREG_SYNC_N = 2;

endpackage

// File: rtl/sreg_link_sync.sv
module sreg_link_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;

    // Both lines idle high, so the pipes reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_prev <= scl_pipe[TOP];
        end
    end

    assign scl_o  = scl_pipe[TOP];
    assign sda_o  = sda_pipe[TOP];
    assign rise_o = scl_pipe[TOP] & ~scl_prev;
    assign fall_o = ~scl_pipe[TOP] & scl_prev;

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned FLAT_W = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAT_W-1:0] flat_o
);

    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
        assign flat_o[g*DATA_W +: DATA_W] = entry[g];
    end

    assign rd_data = entry[addr];

endmodule

// File: rtl/sreg_frame_fsm.sv
module sreg_frame_fsm
    import sreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDLE_W = 16,
    localparam int unsigned FIELD_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int unsigned CNT_W     = $clog2(FIELD_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              rise,
    input  logic              fall,
    input  logic              sda,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              idle_hit_o,
    output logic              dout_o,
    output logic              oe_o
);

    frame_st_e         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-2:0] data_sh;
    logic              rw_q;
    logic [IDLE_W-1:0] idle_cnt;
    logic [DATA_W-1:0] rd_sh;
    logic              idle_hit;

    assign idle_hit = scl_lvl && (idle_cnt >= idle_limit);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (idle_hit) begin
            state_d = ST_IDLE;
        end else if (rise) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ADDR;
                ST_ADDR: if (bit_cnt == CNT_W'(ADDR_W - 1)) state_d = ST_RW;
                ST_RW:   state_d = ST_TURN;
                ST_TURN: state_d = ST_DATA;
                ST_DATA: if (bit_cnt == CNT_W'(DATA_W - 1)) state_d = ST_TAIL;
                ST_TAIL: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register with the frame shifters and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_cnt  <= '0;
            addr_sh  <= '0;
            data_sh  <= '0;
            rw_q     <= 1'b0;
            idle_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (!scl_lvl) begin
                idle_cnt <= '0;
            end else if (idle_cnt != '1) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (idle_hit) begin
                bit_cnt <= '0;
            end else if (rise) begin
                unique case (state_q)
                    ST_IDLE: begin
                        addr_sh <= {addr_sh[ADDR_W-2:0], sda};
                        bit_cnt <= CNT_W'(1);
                    end
                    ST_ADDR: begin
                        addr_sh <= {addr_sh[ADDR_W-2:0], sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RW: begin
                        rw_q <= sda;
                    end
                    ST_TURN: begin
                        bit_cnt <= '0;
                    end
                    ST_DATA: begin
                        data_sh <= {data_sh[DATA_W-3:0], sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_TAIL: begin
                        bit_cnt <= '0;
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // Line drive for read frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_o   <= 1'b0;
            dout_o <= 1'b0;
            rd_sh  <= '0;
        end else if (idle_hit) begin
            oe_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RW: begin
                    if (rise) rd_sh <= rd_data;
                end
                ST_TURN: begin
                    if (fall && rw_q) begin
                        oe_o   <= 1'b1;
                        dout_o <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (fall && rw_q) begin
                        dout_o <= rd_sh[DATA_W-1];
                        rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
                    end
                end
                ST_TAIL: begin
                    if (rise) begin
                        oe_o <= 1'b0;
                    end else if (fall && rw_q) begin
                        dout_o <= 1'b0;
                    end
                end
                default: oe_o <= 1'b0;
            endcase
        end
    end

    assign addr_o     = addr_sh;
    assign wr_en_o    = (state_q == ST_DATA) && rise && !idle_hit && !rw_q
                        && (bit_cnt == CNT_W'(DATA_W - 1));
    assign wr_data_o  = {data_sh, sda};
    assign idle_hit_o = idle_hit;

endmodule

// File: rtl/sreg_link_slave.sv
module sreg_link_slave
    import sreg_pkg::*;
#(
    parameter int unsigned ADDR_W = SREG_ADDR_W,
    parameter int unsigned DATA_W = SREG_DATA_W,
    parameter int unsigned IDLE_W = SREG_IDLE_W,
    parameter int unsigned SYNC_N = SREG_SYNC_N,
    localparam int unsigned FLAT_W = (1 << ADDR_W) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_clk_i,
    input  logic              link_dat_i,
    input  logic [IDLE_W-1:0] idle_limit_i,
    output logic              link_dat_o,
    output logic              link_dat_oe,
    output logic [FLAT_W-1:0] reg_flat_o
);

    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              idle_hit;
    logic              wr_en;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    sreg_link_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (link_clk_i),
        .sda_i  (link_dat_i),
        .scl_o  (scl_lvl),
        .sda_o  (sda_lvl),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    sreg_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDLE_W (IDLE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl    (scl_lvl),
        .rise       (scl_rise),
        .fall       (scl_fall),
        .sda        (sda_lvl),
        .idle_limit (idle_limit_i),
        .rd_data    (rd_data),
        .addr_o     (reg_addr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .idle_hit_o (idle_hit),
        .dout_o     (link_dat_o),
        .oe_o       (link_dat_oe)
    );

    sreg_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (reg_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .flat_o  (reg_flat_o)
    );

endmodule

// File: rtl/sreg_link_checker.sv
module sreg_link_checker #(
    parameter int unsigned FLAT_W = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rise,
    input logic              fall,
    input logic              idle_hit,
    input logic              wr_en,
    input logic              oe,
    input logic              dout,
    input logic [FLAT_W-1:0] regs
);

    // R6: registers move only on a write strobe
    p_hold_unless_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R2: a write strobe lasts one cycle
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: drive starts only after a falling link edge
    p_oe_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(fall));

    // R4: drive ends only after a rising link edge or a timeout
    p_oe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> ($past(rise) || $past(idle_hit)));

    // R3: driven bit changes only after a falling link edge
    p_dout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !fall) |=> $stable(dout));

    // R5: timeout releases the line
    p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |=> !oe);

endmodule

bind sreg_link_slave sreg_link_checker #(.FLAT_W(FLAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (scl_rise),
    .fall     (scl_fall),
    .idle_hit (idle_hit),
    .wr_en    (wr_en),
    .oe       (link_dat_oe),
    .dout     (link_dat_o),
    .regs     (reg_flat_o)
);

// File: tb/sim_sreg_link_slave.sv
`timescale 1ns/1ps
module sim_sreg_link_slave;

    localparam int IDLE_LIM = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lclk = 1'b1;
    logic          mdrv = 1'b1;
    logic          mbit = 1'b1;
    logic          line;
    logic          dout;
    logic          oe;
    logic [2047:0] flat;
    logic [7:0]    mdl [256];
    logic          oe_seen;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    assign line = oe ? dout : (mdrv ? mbit : 1'b1);

    sreg_link_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_clk_i   (lclk),
        .link_dat_i   (line),
        .idle_limit_i (16'(IDLE_LIM)),
        .link_dat_o   (dout),
        .link_dat_oe  (oe),
        .reg_flat_o   (flat)
    );

    always @(posedge clk) if (oe) oe_seen <= 1'b1;

    function automatic logic [7:0] reg_at(input logic [7:0] a);
        return flat[a*8 +: 8];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: bit 18 of fb goes first (R1 order)
    task automatic xfer(input logic [7:0] a, input logic rd, input logic [7:0] wd,
                        input int nbits, input int long_idx, input int gap_ns,
                        output logic [7:0] got);
        logic [18:0] fb;
        fb = {a, rd, 1'b0, (rd ? 8'h00 : wd), 1'b0};
        got = '0;
        @(negedge clk) oe_seen = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            lclk = 1'b0;
            if (rd && i >= 9) mdrv = 1'b0;
            else begin
                mdrv = 1'b1;
                mbit = fb[18-i];
            end
            #100;
            if (rd && i >= 10 && i <= 17) got[17-i] = line;
            lclk = 1'b1;
            if (i == long_idx) #250;
            else #100;
        end
        mdrv = 1'b1;
        mbit = 1'b1;
        #(gap_ns);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int long_idx);
        logic [7:0] g;
        xfer(a, 1'b0, d, 19, long_idx, 400, g);
        mdl[a] = d;
        check(reg_at(a) == d, "R1/R2 write", reg_at(a), d);
        check(!oe_seen, "R4 no drive on write", oe_seen, 0);
    endtask

    task automatic do_read(input logic [7:0] a);
        logic [7:0] g;
        xfer(a, 1'b1, 8'h00, 19, -1, 400, g);
        check(g == mdl[a], "R3 read", g, mdl[a]);
        check(oe_seen && !oe, "R4 drive window", {oe_seen, oe}, 2);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] g;
        logic [7:0] a;
        logic [7:0] d;
        logic       ok;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        #53;
        rst_n = 1'b1;
        #200;
        check(!oe, "R7 reset drive", oe, 0);
        check(flat == '0, "R7 reset regs", flat[31:0], 0);

        do_write(8'h52, 8'h01, -1);
        do_read(8'h52);
        do_write(8'hAA, 8'h55, -1);
        do_read(8'hAA);
        do_read(8'h00);

        // R6: cut after five data bits, nothing stored
        xfer(8'h10, 1'b0, 8'hFF, 15, -1, 400, g);
        check(reg_at(8'h10) == 8'h00, "R6 cut write", reg_at(8'h10), 0);
        // R5: realigned after timeout
        do_write(8'h11, 8'h3C, -1);
        check(reg_at(8'h10) == 8'h00, "R5 realign", reg_at(8'h10), 0);

        // R6: trailing bit missing still commits
        xfer(8'h20, 1'b0, 8'hA5, 18, -1, 400, g);
        mdl[8'h20] = 8'hA5;
        check(reg_at(8'h20) == 8'hA5, "R6 commit without tail", reg_at(8'h20), 8'hA5);

        // R5: read abandoned mid data releases the line
        xfer(8'h52, 1'b1, 8'h00, 13, -1, 400, g);
        check(!oe, "R5 release after timeout", oe, 0);
        do_read(8'h20);

        // R8: stretched high phases below the limit
        do_write(8'h30, 8'h96, 4);
        do_write(8'h31, 8'h69, 12);

        do_write(8'hFF, 8'h80, -1);
        do_read(8'hFF);
        do_write(8'h00, 8'h7E, -1);
        do_read(8'h00);

        // Random frames with gaps just above the idle limit (R5/R1)
        for (int n = 0; n < 40; n++) begin
            a = 8'($urandom);
            d = 8'($urandom);
            if ($urandom % 2 == 0) begin
                xfer(a, 1'b0, d, 19, -1, 320 + int'($urandom % 300), g);
                mdl[a] = d;
                check(reg_at(a) == d, "R2 random write", reg_at(a), d);
            end else begin
                xfer(a, 1'b1, 8'h00, 19, -1, 320 + int'($urandom % 300), g);
                check(g == mdl[a], "R3 random read", g, mdl[a]);
            end
        end

        // R9: whole flat view against the model
        ok = 1'b1;
        for (int i = 0; i < 256; i++) if (flat[i*8 +: 8] != mdl[i]) ok = 1'b0;
        check(ok, "R9 flat view", ok, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule